// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for a two-wire PHY management bus that uses single-register frames with a 5-bit PHY address and a 5-bit register address. A host writes a request word with a start flag set. The controller then runs one read or write frame on the bus, and the start flag drops when the frame is done. For reads, the controller returns an acknowledge flag and 16 data bits. The management clock is divided down from the system clock. The data line is driven through an output enable so that the PHY can take the line for turnaround and read data.

When the engine is enabled and no host request is waiting, it sweeps all 32 PHY addresses with reads of one fixed register. It records the PHYs that answered in a 32-bit presence map. A host request that arrives during a sweep read waits for that read to finish and is served before the next sweep read. Clearing the enable lets the current frame finish and then idles the bus. A manual mode hands the clock, the output enable and the output data directly to register bits, and returns the sampled pin state.

Top module: `mdio_master`

Register word addresses:
- 0: control. Bit 31 reads back the idle flag, bit 30 is enable, and bits 15:0 are the divider.
- 1: request. Bit 31 is go, bit 30 is write (0 means read), bit 29 is ack, bits 25:21 are the register address, bits 20:16 are the PHY address, and bits 15:0 are data.
- 2: presence map.
- 3: mode. Bit 31 selects manual mode.
- 4: manual pins. Bit 2 is the clock, bit 1 is the output enable, and bit 0 is the output data; bit 0 reads back the sampled pin.

## Requirements
- R1: After reset, the control word reads 32'h8000_0000 (idle, disabled, divider 0), the request word and the presence map read 0, and mdioOe is low.
- R2: The mdc output has a period of divider+1 system clocks for divider values of 1 or more, and a period of 2 clocks when the divider is 0.
- R3: A write frame drives 32 ones, then 01, then the opcode 01, then the PHY address MSB first, then the register address MSB first, then 10, then 16 data bits MSB first. MDIO changes only when mdc falls, and is sampled when mdc rises.
- R4: A read frame uses opcode 10 and releases MDIO for both turnaround bits and the data bits. The ack flag (bit 29) is set only when the PHY drove the second turnaround bit low. The data field then holds the 16 returned bits, MSB first.
- R5: A read of an address where no PHY drives the line completes with ack clear.
- R6: Go (bit 31) reads 1 from the request write until the frame completes, and then reads 0. A request write made while go is set changes no field and starts no frame.
- R7: Bit n of the presence map equals the ack result of the most recent sweep read of PHY address n. The sweep reads register 1.
- R8: A host request is served before any further sweep read. At most one sweep frame header appears on the bus between the request write and the host frame.
- R9: When enable is cleared during a frame, the idle flag stays 0 until that frame completes, then reads 1. No further frame starts, and mdioOe stays low.
- R10: With mode bit 31 set, mdc, mdioOe and mdioOut follow manual bits 2, 1 and 0. Manual bits 2:1 read back as written, and bit 0 reads back the sampled mdioIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data out |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data pin as seen on the board |

## Verification
The assertions assume that mdioIn changes only while mdc is low, as a PHY that answers on the falling edge behaves. They also assume that the divider is not rewritten during a frame, and that the enable and mode bits are not both toggled while a frame runs. The stimulus uses a behavioural PHY that updates its output only on the falling edge of mdc. Divider changes are made only while the engine is disabled. Manual mode is entered only after the bus has gone idle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_USER   = 3'd1;
  localparam logic [2:0] ADDR_ALIVE  = 3'd2;
  localparam logic [2:0] ADDR_MODE   = 3'd3;
  localparam logic [2:0] ADDR_MANUAL = 3'd4;

  typedef struct packed {
    logic        start;
    logic        isRead;
    logic [4:0]  phy;
    logic [4:0]  regAddr;
    logic [15:0] wdata;
  } frameReq_t;

  typedef struct packed {
    logic        done;
    logic        ack;
    logic [15:0] rdata;
  } frameRsp_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HOST, SEQ_SCAN} seqState_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameReq_t        req,
  input  logic [DIV_W-1:0] div,
  input  logic             manualMode,
  input  logic [2:0]       manualIf,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output frameRsp_t        rsp,
  output logic             pinSample
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [DIV_W-1:0]     phaseCnt, lastCnt, halfCnt;
  logic [DIV_W:0]       periodWide;
  logic                 fallTick, riseTick, genMdc;
  logic                 armed, active, isRead, taSample, doneQ;
  logic [IDX_W-1:0]     idx;
  logic [FRAME_LEN-1:0] shiftReg;
  logic [15:0]          rdata;

  // Phase counter: low half first, falling edge at wrap.
  always_comb begin
    lastCnt    = (div == '0) ? DIV_W'(1) : div;
    periodWide = {1'b0, lastCnt} + 1'b1;
    halfCnt    = periodWide[DIV_W:1];
    fallTick   = phaseCnt >= lastCnt;
    riseTick   = phaseCnt == (halfCnt - 1'b1);
    genMdc     = phaseCnt >= halfCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      armed     <= 1'b0;
      active    <= 1'b0;
      isRead    <= 1'b0;
      taSample  <= 1'b1;
      doneQ     <= 1'b0;
      idx       <= '0;
      shiftReg  <= '1;
      rdata     <= '0;
      pinSample <= 1'b0;
    end else begin
      doneQ     <= 1'b0;
      pinSample <= mdioIn;
      phaseCnt  <= fallTick ? '0 : phaseCnt + 1'b1;
      if (req.start) begin
        armed    <= 1'b1;
        isRead   <= req.isRead;
        shiftReg <= {{PRE_LEN{1'b1}}, 2'b01,
                     req.isRead ? 2'b10 : 2'b01,
                     req.phy, req.regAddr,
                     req.isRead ? 2'b11 : 2'b10,
                     req.isRead ? 16'hFFFF : req.wdata};
      end else if (fallTick) begin
        if (armed) begin
          armed  <= 1'b0;
          active <= 1'b1;
          idx    <= '0;
        end else if (active) begin
          if (idx == LAST_IDX) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end else begin
            idx      <= idx + 1'b1;
            shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
          end
        end
      end
      if (active && riseTick) begin
        if (idx == ACK_IDX) taSample <= mdioIn;
        if (idx >= DATA_IDX) rdata <= {rdata[14:0], mdioIn};
      end
    end
  end

  assign mdc     = manualMode ? manualIf[2] : genMdc;
  assign mdioOut = manualMode ? manualIf[0] : (active ? shiftReg[FRAME_LEN-1] : 1'b1);
  assign mdioOe  = manualMode ? manualIf[1] : (active && !(isRead && idx >= TA_IDX));
  assign rsp     = '{done: doneQ, ack: !taSample, rdata: rdata};
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int          DIV_W    = 16,
  parameter logic [4:0]  SCAN_REG = 5'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  frameRsp_t        rsp,
  input  logic             pinSample,
  output frameReq_t        req,
  output logic [DIV_W-1:0] div,
  output logic             manualMode,
  output logic [2:0]       manualIf,
  output logic             idle,
  output logic [31:0]      userReg,
  output logic [31:0]      aliveMap
);
  seqState_t   state;
  logic        enable, uGo, uWrite, uAck, launch;
  logic [4:0]  uReg, uPhy, scanAddr;
  logic [15:0] uData;
  logic [31:0] ctrlWord;
  logic        unusedWr;

  assign unusedWr = ^regWrData[29:26];
  assign idle     = state == SEQ_IDLE;
  assign launch   = idle && enable && !manualMode;
  assign userReg  = {uGo, uWrite, uAck, 3'b000, uReg, uPhy, uData};

  // Host request wins over the sweep at every frame boundary.
  always_comb begin
    req.start   = launch;
    req.isRead  = uGo ? !uWrite : 1'b1;
    req.phy     = uGo ? uPhy : scanAddr;
    req.regAddr = uGo ? uReg : SCAN_REG;
    req.wdata   = uData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;  enable <= 1'b0;  div <= '0;
      uGo <= 1'b0;  uWrite <= 1'b0;  uAck <= 1'b0;
      uReg <= '0;  uPhy <= '0;  uData <= '0;
      aliveMap <= '0;  scanAddr <= '0;
      manualMode <= 1'b0;  manualIf <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          ADDR_CTRL: begin
            enable <= regWrData[30];
            div    <= regWrData[DIV_W-1:0];
          end
          ADDR_USER: if (!uGo) begin
            uGo    <= regWrData[31];
            uWrite <= regWrData[30];
            uAck   <= 1'b0;
            uReg   <= regWrData[25:21];
            uPhy   <= regWrData[20:16];
            uData  <= regWrData[15:0];
          end
          ADDR_MODE:   manualMode <= regWrData[31];
          ADDR_MANUAL: manualIf   <= regWrData[2:0];
          default: ;
        endcase
      end
      case (state)
        SEQ_IDLE: if (launch) state <= uGo ? SEQ_HOST : SEQ_SCAN;
        SEQ_HOST: if (rsp.done) begin
          state <= SEQ_IDLE;
          uGo   <= 1'b0;
          uAck  <= !uWrite && rsp.ack;
          if (!uWrite) uData <= rsp.rdata;
        end
        SEQ_SCAN: if (rsp.done) begin
          state              <= SEQ_IDLE;
          aliveMap[scanAddr] <= rsp.ack;
          scanAddr           <= scanAddr + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlWord             = '0;
    ctrlWord[31]         = idle;
    ctrlWord[30]         = enable;
    ctrlWord[DIV_W-1:0]  = div;
    case (regAddr)
      ADDR_CTRL:   regRdData = ctrlWord;
      ADDR_USER:   regRdData = userReg;
      ADDR_ALIVE:  regRdData = aliveMap;
      ADDR_MODE:   regRdData = {manualMode, 31'b0};
      ADDR_MANUAL: regRdData = {29'b0, manualIf[2:1], pinSample};
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         DIV_W    = 16,
  parameter int         PRE_LEN  = 32,
  parameter logic [4:0] SCAN_REG = 5'd1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  frameReq_t        dpReq;
  frameRsp_t        dpRsp;
  logic [DIV_W-1:0] div;
  logic             manualMode, idleFlag, pinSample, frameDone;
  logic [2:0]       manualIf;
  logic [31:0]      userReg, aliveMap;

  assign frameDone = dpRsp.done;

  mdio_ctrl #(.DIV_W(DIV_W), .SCAN_REG(SCAN_REG)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .rsp(dpRsp),
    .pinSample(pinSample), .req(dpReq), .div(div), .manualMode(manualMode),
    .manualIf(manualIf), .idle(idleFlag), .userReg(userReg), .aliveMap(aliveMap)
  );

  mdio_datapath #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .req(dpReq), .div(div), .manualMode(manualMode),
    .manualIf(manualIf), .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .rsp(dpRsp), .pinSample(pinSample)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        manualMode,
  input logic        idle,
  input logic        frameDone,
  input logic [31:0] userReg,
  input logic [31:0] aliveMap
);
  p_line_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!manualMode && !$past(manualMode) && mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));

  p_go_drop_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(userReg[31]) |-> $past(frameDone));

  p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(userReg[31]) && userReg[31]) |-> $stable(userReg[30:0]));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !manualMode) |-> !mdioOe);

  p_alive_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(aliveMap) |-> ($past(frameDone) && $countones(aliveMap ^ $past(aliveMap)) == 1));

  p_ack_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userReg[29]) |-> (!userReg[30] && !userReg[31]));
endmodule

bind mdio_master mdio_master_chk i_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .manualMode(manualMode), .idle(idleFlag), .frameDone(frameDone),
  .userReg(userReg), .aliveMap(aliveMap)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  localparam logic [31:0] PRESENT = 32'h8000_4213;
  localparam logic [4:0]  SCANREG = 5'd1;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // Behavioural PHY set on the bus
  logic        forceLow = 1'b0;
  logic        phyDrive = 1'b0;
  logic        phyBit = 1'b1;
  logic [15:0] phyMem [0:1023];
  int          mState = 0, ones = 0, hCnt = 0, tCnt = 0, dCnt = 0;
  logic [11:0] hdr = '0;
  logic [15:0] dSh = '0;
  logic        mRead = 1'b0, mHit = 1'b0;
  logic [4:0]  mPhy = '0, mReg = '0;
  int          frameCnt = 0, framesDone = 0, lastHostIdx = 0, wrCnt = 0;
  logic [25:0] lastWr = '0;

  assign mdioIn = forceLow ? 1'b0 : (mdioOe ? mdioOut : (phyDrive ? phyBit : 1'b1));

  initial begin
    for (int i = 0; i < 1024; i++) phyMem[i] = 16'(i * 40503) ^ 16'h5A5A;
  end

  always @(posedge mdc) begin
    logic [11:0] h;
    case (mState)
      0: if (mdioIn) ones = ones + 1;
         else begin
           if (ones >= 32) mState = 1;
           ones = 0;
         end
      1: if (mdioIn) begin mState = 2; hCnt = 0; end
         else mState = 0;
      2: begin
        h = {hdr[10:0], mdioIn};
        hdr = h;
        hCnt = hCnt + 1;
        if (hCnt == 12) begin
          mRead = h[11:10] == 2'b10;
          mPhy = h[9:5];
          mReg = h[4:0];
          mHit = PRESENT[h[9:5]];
          frameCnt = frameCnt + 1;
          if (h[4:0] != SCANREG) lastHostIdx = frameCnt;
          mState = 3;
          tCnt = 0;
        end
      end
      3: begin
        tCnt = tCnt + 1;
        if (tCnt == 2) begin mState = 4; dCnt = 0; end
      end
      default: begin
        dSh = {dSh[14:0], mdioIn};
        dCnt = dCnt + 1;
        if (dCnt == 16) begin
          if (!mRead) begin
            lastWr = {mPhy, mReg, dSh};
            wrCnt = wrCnt + 1;
            if (mHit) phyMem[{mPhy, mReg}] = dSh;
          end
          framesDone = framesDone + 1;
          mState = 0;
          ones = 0;
        end
      end
    endcase
  end

  always @(negedge mdc) begin
    phyDrive = 1'b0;
    if (mHit && mRead) begin
      if (mState == 3 && tCnt == 1) begin phyDrive = 1'b1; phyBit = 1'b0; end
      else if (mState == 4) begin
        phyDrive = 1'b1;
        phyBit = phyMem[{mPhy, mReg}][15 - dCnt];
      end
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic waitGo(output int cyc);
    logic [31:0] v;
    cyc = 0;
    regRead(3'd1, v);
    while (v[31] && cyc < 3000) begin
      regRead(3'd1, v);
      cyc++;
    end
  endtask

  task automatic hostOp(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, output logic [31:0] res, output int gap);
    int c0, cyc;
    c0 = frameCnt;
    regWrite(3'd1, {1'b1, wr, 4'b0, rg, phy, d});
    waitGo(cyc);
    regRead(3'd1, res);
    gap = lastHostIdx - c0;
  endtask

  initial begin
    logic [31:0] v, res;
    int gap, t1, t2, wc, fc, oeBad, cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd0, v); checkEq("R1 control", v, 32'h8000_0000);
    regRead(3'd1, v); checkEq("R1 request", v, 32'h0);
    regRead(3'd2, v); checkEq("R1 presence", v, 32'h0);
    checkEq("R1 mdioOe", {31'b0, mdioOe}, 32'h0);

    // R2 divider sweep
    for (int d = 0; d < 10; d++) begin
      regWrite(3'd0, 32'(d));
      @(posedge mdc); @(posedge mdc);
      t1 = int'($time); @(posedge mdc); t2 = int'($time);
      checkEq($sformatf("R2 period div=%0d", d), 32'((t2 - t1) / 10), (d == 0) ? 32'd2 : 32'(d + 1));
    end

    // R7 sweep fills presence map
    regWrite(3'd0, 32'h4000_0001);
    repeat (6000) @(negedge clk);
    regRead(3'd2, v); checkEq("R7 presence map", v, PRESENT);

    // R3 write frame, R8 priority
    wc = wrCnt;
    hostOp(1'b1, 5'd4, 5'd9, 16'hBEEF, res, gap);
    checkEq("R3 write frame content", {6'b0, lastWr}, {6'b0, 5'd4, 5'd9, 16'hBEEF});
    checkEq("R3 one write frame", 32'(wrCnt - wc), 32'd1);
    checkEq("R8 header gap", 32'(gap <= 2 && gap >= 1), 32'd1);

    // R4/R5 read sweep over all addresses
    for (int a = 0; a < 32; a++) begin
      logic [4:0] rg;
      rg = 5'((a * 7 + 2) & 31);
      if (rg == SCANREG) rg = 5'd2;
      if (a == 4) rg = 5'd9;
      hostOp(1'b0, 5'(a), rg, 16'h0, res, gap);
      checkEq($sformatf("R8 gap a=%0d", a), 32'(gap <= 2 && gap >= 1), 32'd1);
      if (PRESENT[a]) begin
        checkEq($sformatf("R4 ack a=%0d", a), {31'b0, res[29]}, 32'd1);
        checkEq($sformatf("R4 data a=%0d", a), {16'b0, res[15:0]}, {16'b0, phyMem[{5'(a), rg}]});
      end else begin
        checkEq($sformatf("R5 no ack a=%0d", a), {31'b0, res[29]}, 32'd0);
      end
    end

    // R6 go readback and ignored request
    wc = wrCnt;
    regWrite(3'd1, {1'b1, 1'b0, 4'b0, 5'd9, 5'd4, 16'h0});
    regRead(3'd1, v); checkEq("R6 go pending", {31'b0, v[31]}, 32'd1);
    regWrite(3'd1, {1'b1, 1'b1, 4'b0, 5'd3, 5'd14, 16'h1234});
    waitGo(cyc);
    regRead(3'd1, v);
    checkEq("R6 go cleared", {31'b0, v[31]}, 32'd0);
    checkEq("R6 fields kept", {6'b0, v[25:16]}, {6'b0, 5'd9, 5'd4});
    checkEq("R6 read result", {15'b0, v[29], v[15:0]}, {15'b0, 1'b1, 16'hBEEF});
    repeat (400) @(negedge clk);
    checkEq("R6 no ignored frame", 32'(wrCnt - wc), 32'd0);

    // R9 disable mid-frame
    fc = frameCnt;
    while (frameCnt == fc) @(negedge clk);
    regWrite(3'd0, 32'h0000_0001);
    regRead(3'd0, v); checkEq("R9 busy after disable", {31'b0, v[31]}, 32'd0);
    cyc = 0;
    while (!v[31] && cyc < 300) begin regRead(3'd0, v); cyc++; end
    checkEq("R9 idle reached", {31'b0, v[31]}, 32'd1);
    checkEq("R9 frame finished", 32'(framesDone), 32'(frameCnt));
    fc = frameCnt; oeBad = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (mdioOe) oeBad++; end
    checkEq("R9 no new frame", 32'(frameCnt), 32'(fc));
    checkEq("R9 oe low", 32'(oeBad), 32'd0);

    // R10 manual mode, exhaustive pin codes
    regWrite(3'd3, 32'h8000_0000);
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 2; f++) begin
        regWrite(3'd4, 32'(m));
        forceLow = f[0];
        @(negedge clk); @(negedge clk);
        checkEq($sformatf("R10 pins m=%0d", m), {29'b0, mdc, mdioOe, mdioOut}, 32'(m));
        regRead(3'd4, v);
        checkEq($sformatf("R10 readback m=%0d f=%0d", m, f), {29'b0, v[2:0]},
                {29'b0, 2'(m >> 1), f[0] ? 1'b0 : (m[1] ? m[0] : mdioIn)});
      end
    end
    forceLow = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule